// File: doc/BRIEF.md
# Segmented Set-Associative Read Cache Controller

This block sits between a processor load port and a slower word-wide memory bus. It keeps tags, valid bits and line data for a highly associative read cache: 8 segments, each holding 64 lines of 8 words. A cacheable load that hits is answered in the same cycle and causes no bus activity. A cacheable miss fetches the whole line as an in-order burst. The requested word is handed to the processor as soon as it arrives. A load flagged as non-cacheable becomes a single-word bus read and leaves the cache unchanged.

The victim way is chosen per segment. After reset a free-running shift-register sequence picks it. When the policy input is set, each segment instead keeps its own rotating pointer. A lockdown base, one way wide, protects the ways below it from eviction in every segment. A single-cycle invalidate input clears all valid bits.

Top module: `seg_cache_ctrl`

## Requirements
- R1: A byte address is split as follows: bits [31:8] are the line tag, bits [7:5] select the segment, and bits [4:2] select the word within the line. The word returned on a hit is the word stored at that segment, way and word offset.
- R2: When `req_i` and `cacheable_i` are high in the idle state and the address matches a valid line, `ready_o` is high in that same cycle, `rdata_o` carries the cached word, and `mem_req_o` stays low.
- R3: A cacheable miss raises `mem_req_o` and `mem_burst_o` from the next cycle. `mem_addr_o` holds the line base address (bits [4:0] zero). Both stay up until eight `mem_valid_i` beats have been taken, with word offsets 0 to 7 in that order.
- R4: During a linefill, `ready_o` is high only in the cycle of the beat whose offset equals the requested word. In that cycle `rdata_o` equals `mem_rdata_i`.
- R5: No new request is served until the final beat of a fill has been taken. The filled line gives hits from the following cycle onward.
- R6: A request with `cacheable_i` low produces one bus read from the next cycle. `mem_burst_o` is low and `mem_addr_o` is the word-aligned address. The beat is forwarded with `ready_o`, and nothing is allocated.
- R7: With `policy_rr_i` low, the victim is the value of a 6-bit shift register. The register is 1 after reset and steps every clock as next = {q[4:0], q[5]^q[4]}. The value used is the one present in the miss cycle, raised to the lockdown base if it is below it.
- R8: With `policy_rr_i` high, each segment has a pointer that is 0 after reset. The victim is the larger of the pointer and the lockdown base. When such a fill completes, the pointer becomes victim+1, or the base if the victim was way 63. Pointers move only on fills begun in this mode.
- R9: Ways numbered below `lock_base_i` (sampled in the miss cycle) are never replaced, whichever policy is selected.
- R10: A cycle with `inval_i` high makes every line invalid from the next cycle on.
- R11: If `inval_i` is high in the cycle of a fill's final beat, the filled line is not valid afterwards.
- R12: A hit in the same cycle as `inval_i` is still answered from the cache contents of that cycle.
- R13: In reset (`rst_ni` low), `ready_o` and `mem_req_o` are low, and no line is valid afterwards.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| req_i | input | 1 | Load request, held until `ready_o` |
| addr_i | input | 32 | Byte address of the load |
| cacheable_i | input | 1 | Load may use and allocate into the cache |
| ready_o | output | 1 | Load data valid this cycle |
| rdata_o | output | 32 | Load data |
| policy_rr_i | input | 1 | 0: shift-register victim, 1: per-segment rotating victim |
| lock_base_i | input | 6 | First way that may be evicted |
| inval_i | input | 1 | Clear every valid bit |
| mem_req_o | output | 1 | Bus read active |
| mem_burst_o | output | 1 | Bus read is an 8-word line burst |
| mem_addr_o | output | 32 | Bus read address (line base or word) |
| mem_valid_i | input | 1 | Bus beat valid |
| mem_rdata_i | input | 32 | Bus beat data |

## Verification
Invalidate can land in the same cycle as two other events. The first is the last beat of a linefill, where the line install and the valid clear fight over the same bit. The bench arms a flag so that its memory responder raises `inval_i` exactly on the eighth beat. It then re-reads that line and expects a miss. The second is a same-cycle hit. The bench raises `inval_i` together with a request to a resident line and expects the data in that cycle, followed by a miss on the next access. A behavioural model of tags, valid bits, pointers and the shift register predicts every output on every clock.

// File: rtl/seg_cache_pkg.sv
package seg_cache_pkg;
  typedef enum logic [1:0] {
    ST_IDLE   = 2'd0,
    ST_FILL   = 2'd1,
    ST_SINGLE = 2'd2
  } fsm_e;
endpackage

// File: rtl/sc_tag_array.sv
module sc_tag_array #(
  parameter int SEGS  = 8,
  parameter int WAYS  = 64,
  parameter int TAG_W = 24,
  localparam int SEG_W = $clog2(SEGS),
  localparam int WAY_W = $clog2(WAYS)
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic [SEG_W-1:0] lk_seg_i,
  input  logic [TAG_W-1:0] lk_tag_i,
  output logic             hit_o,
  output logic [WAY_W-1:0] hit_way_o,
  input  logic             inval_i,
  input  logic             wr_en_i,
  input  logic [SEG_W-1:0] wr_seg_i,
  input  logic [WAY_W-1:0] wr_way_i,
  input  logic [TAG_W-1:0] wr_tag_i
);
  logic [WAYS-1:0]  valid_q [SEGS];
  logic [TAG_W-1:0] tag_q   [SEGS][WAYS];
  logic [WAYS-1:0]  match_vec;
  logic             any_valid;

  for (genvar w = 0; w < WAYS; w++) begin : g_cmp
    assign match_vec[w] = valid_q[lk_seg_i][w] && (tag_q[lk_seg_i][w] == lk_tag_i);
  end

  assign hit_o = |match_vec;

  always_comb begin
    hit_way_o = '0;
    for (int w = 0; w < WAYS; w++)
      if (match_vec[w]) hit_way_o = hit_way_o | WAY_W'(w);
  end

  always_comb begin
    any_valid = 1'b0;
    for (int s = 0; s < SEGS; s++) any_valid = any_valid | (|valid_q[s]);
  end

  // invalidate wins over a same-cycle install
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      for (int s = 0; s < SEGS; s++) valid_q[s] <= '0;
    end else if (inval_i) begin
      for (int s = 0; s < SEGS; s++) valid_q[s] <= '0;
    end else if (wr_en_i) begin
      valid_q[wr_seg_i][wr_way_i] <= 1'b1;
    end
  end

  always_ff @(posedge clk_i) begin
    if (wr_en_i) tag_q[wr_seg_i][wr_way_i] <= wr_tag_i;
  end

  // R2
  single_match_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $onehot0(match_vec));

  // R10
  inval_clears_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    inval_i |=> !any_valid);
endmodule

// File: rtl/sc_data_array.sv
module sc_data_array #(
  parameter int ADDR_BITS = 12,
  parameter int DATA_W    = 32,
  localparam int DEPTH    = 1 << ADDR_BITS
) (
  input  logic                 clk_i,
  input  logic [ADDR_BITS-1:0] rd_addr_i,
  output logic [DATA_W-1:0]    rd_data_o,
  input  logic                 wr_en_i,
  input  logic [ADDR_BITS-1:0] wr_addr_i,
  input  logic [DATA_W-1:0]    wr_data_i
);
  logic [DATA_W-1:0] mem_q [DEPTH];

  assign rd_data_o = mem_q[rd_addr_i];

  always_ff @(posedge clk_i) begin
    if (wr_en_i) mem_q[wr_addr_i] <= wr_data_i;
  end
endmodule

// File: rtl/sc_victim.sv
module sc_victim #(
  parameter int SEGS = 8,
  parameter int WAYS = 64,
  localparam int SEG_W = $clog2(SEGS),
  localparam int WAY_W = $clog2(WAYS),
  parameter logic [WAY_W-1:0] TAPS = 6'b110000
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic [SEG_W-1:0] seg_i,
  input  logic             rr_mode_i,
  input  logic [WAY_W-1:0] base_i,
  output logic [WAY_W-1:0] victim_o,
  input  logic             adv_i,
  input  logic [SEG_W-1:0] adv_seg_i,
  input  logic [WAY_W-1:0] adv_way_i,
  input  logic [WAY_W-1:0] adv_base_i
);
  localparam logic [WAY_W-1:0] LAST_WAY = WAY_W'(WAYS - 1);

  logic [WAY_W-1:0] lfsr_q;
  logic [WAY_W-1:0] ptr_q [SEGS];
  logic [WAY_W-1:0] rnd_pick, rr_pick;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) lfsr_q <= WAY_W'(1);
    else         lfsr_q <= {lfsr_q[WAY_W-2:0], ^(lfsr_q & TAPS)};
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      for (int s = 0; s < SEGS; s++) ptr_q[s] <= '0;
    end else if (adv_i) begin
      ptr_q[adv_seg_i] <= (adv_way_i == LAST_WAY) ? adv_base_i : adv_way_i + 1'b1;
    end
  end

  // both sources are clamped up to the lockdown base
  assign rnd_pick = (lfsr_q < base_i) ? base_i : lfsr_q;
  assign rr_pick  = (ptr_q[seg_i] < base_i) ? base_i : ptr_q[seg_i];
  assign victim_o = rr_mode_i ? rr_pick : rnd_pick;

  // R9
  victim_unlocked_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    victim_o >= base_i);

  // R8
  rr_step_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (adv_i && adv_way_i != LAST_WAY) |=> ptr_q[$past(adv_seg_i)] == $past(adv_way_i) + 1'b1);
endmodule

// File: rtl/seg_cache_ctrl.sv
module seg_cache_ctrl
  import seg_cache_pkg::*;
#(
  parameter int ADDR_W = 32,
  parameter int DATA_W = 32,
  parameter int SEGS   = 8,
  parameter int WAYS   = 64,
  parameter int WORDS  = 8,
  localparam int WAY_W = $clog2(WAYS),
  parameter logic [WAY_W-1:0] LFSR_TAPS = 6'b110000
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              req_i,
  input  logic [ADDR_W-1:0] addr_i,
  input  logic              cacheable_i,
  output logic              ready_o,
  output logic [DATA_W-1:0] rdata_o,
  input  logic              policy_rr_i,
  input  logic [WAY_W-1:0]  lock_base_i,
  input  logic              inval_i,
  output logic              mem_req_o,
  output logic              mem_burst_o,
  output logic [ADDR_W-1:0] mem_addr_o,
  input  logic              mem_valid_i,
  input  logic [DATA_W-1:0] mem_rdata_i
);
  localparam int OFF_W  = $clog2(DATA_W / 8);
  localparam int WRD_W  = $clog2(WORDS);
  localparam int SEG_W  = $clog2(SEGS);
  localparam int TAG_W  = ADDR_W - OFF_W - WRD_W - SEG_W;
  localparam int DADR_W = SEG_W + WAY_W + WRD_W;
  localparam logic [WRD_W-1:0] LAST_BEAT = WRD_W'(WORDS - 1);

  fsm_e              state_q;
  logic [TAG_W-1:0]  ln_tag_q;
  logic [SEG_W-1:0]  ln_seg_q;
  logic [WRD_W-1:0]  ln_word_q;
  logic [WAY_W-1:0]  ln_way_q;
  logic [WAY_W-1:0]  ln_base_q;
  logic              ln_rr_q;
  logic [WRD_W-1:0]  beat_q;
  logic [ADDR_W-OFF_W-1:0] single_q;

  logic [TAG_W-1:0]  cur_tag;
  logic [SEG_W-1:0]  cur_seg;
  logic [WRD_W-1:0]  cur_word;
  logic              hit;
  logic [WAY_W-1:0]  hit_way;
  logic [WAY_W-1:0]  victim;
  logic [DATA_W-1:0] arr_rdata;
  logic              idle_req, lookup_hit, fill_beat, last_beat;
  logic              unused_lsb;

  assign cur_tag    = addr_i[ADDR_W-1 -: TAG_W];
  assign cur_seg    = addr_i[OFF_W+WRD_W +: SEG_W];
  assign cur_word   = addr_i[OFF_W +: WRD_W];
  assign unused_lsb = ^addr_i[OFF_W-1:0];

  assign idle_req   = (state_q == ST_IDLE) && req_i;
  assign lookup_hit = idle_req && cacheable_i && hit;
  assign fill_beat  = (state_q == ST_FILL) && mem_valid_i;
  assign last_beat  = fill_beat && (beat_q == LAST_BEAT);

  sc_tag_array #(.SEGS(SEGS), .WAYS(WAYS), .TAG_W(TAG_W)) u_tags (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .lk_seg_i  (cur_seg),
    .lk_tag_i  (cur_tag),
    .hit_o     (hit),
    .hit_way_o (hit_way),
    .inval_i   (inval_i),
    .wr_en_i   (last_beat),
    .wr_seg_i  (ln_seg_q),
    .wr_way_i  (ln_way_q),
    .wr_tag_i  (ln_tag_q)
  );

  sc_data_array #(.ADDR_BITS(DADR_W), .DATA_W(DATA_W)) u_data (
    .clk_i     (clk_i),
    .rd_addr_i ({cur_seg, hit_way, cur_word}),
    .rd_data_o (arr_rdata),
    .wr_en_i   (fill_beat),
    .wr_addr_i ({ln_seg_q, ln_way_q, beat_q}),
    .wr_data_i (mem_rdata_i)
  );

  sc_victim #(.SEGS(SEGS), .WAYS(WAYS), .TAPS(LFSR_TAPS)) u_victim (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .seg_i      (cur_seg),
    .rr_mode_i  (policy_rr_i),
    .base_i     (lock_base_i),
    .victim_o   (victim),
    .adv_i      (last_beat && ln_rr_q),
    .adv_seg_i  (ln_seg_q),
    .adv_way_i  (ln_way_q),
    .adv_base_i (ln_base_q)
  );

  always_comb begin
    ready_o = 1'b0;
    rdata_o = '0;
    unique case (state_q)
      ST_IDLE: begin
        ready_o = lookup_hit;
        if (lookup_hit) rdata_o = arr_rdata;
      end
      ST_FILL: begin
        ready_o = fill_beat && (beat_q == ln_word_q);
        if (ready_o) rdata_o = mem_rdata_i;
      end
      ST_SINGLE: begin
        ready_o = mem_valid_i;
        if (mem_valid_i) rdata_o = mem_rdata_i;
      end
      default: ;
    endcase
  end

  assign mem_req_o   = (state_q != ST_IDLE);
  assign mem_burst_o = (state_q == ST_FILL);
  assign mem_addr_o  = (state_q == ST_FILL)   ? {ln_tag_q, ln_seg_q, {(WRD_W+OFF_W){1'b0}}} :
                       (state_q == ST_SINGLE) ? {single_q, {OFF_W{1'b0}}} : '0;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q   <= ST_IDLE;
      ln_tag_q  <= '0;
      ln_seg_q  <= '0;
      ln_word_q <= '0;
      ln_way_q  <= '0;
      ln_base_q <= '0;
      ln_rr_q   <= 1'b0;
      beat_q    <= '0;
      single_q  <= '0;
    end else begin
      unique case (state_q)
        ST_IDLE: begin
          if (idle_req && !cacheable_i) begin
            single_q <= addr_i[ADDR_W-1:OFF_W];
            state_q  <= ST_SINGLE;
          end else if (idle_req && !hit) begin
            ln_tag_q  <= cur_tag;
            ln_seg_q  <= cur_seg;
            ln_word_q <= cur_word;
            ln_way_q  <= victim;
            ln_base_q <= lock_base_i;
            ln_rr_q   <= policy_rr_i;
            beat_q    <= '0;
            state_q   <= ST_FILL;
          end
        end
        ST_FILL: begin
          if (fill_beat) beat_q <= beat_q + 1'b1;
          if (last_beat) state_q <= ST_IDLE;
        end
        ST_SINGLE: begin
          if (mem_valid_i) state_q <= ST_IDLE;
        end
        default: state_q <= ST_IDLE;
      endcase
    end
  end

  // R3
  bus_hold_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (mem_req_o && !mem_valid_i) |=> (mem_req_o && $stable(mem_addr_o) && $stable(mem_burst_o)));

  // R5
  fill_no_hit_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    mem_burst_o |-> !(ready_o && !mem_valid_i));
endmodule

// File: tb/seg_cache_ctrl_test.sv
`timescale 1ns/1ps
module seg_cache_ctrl_test;
  logic        clk = 1'b0;
  logic        rst_ni = 1'b0;
  logic        req_i = 1'b0;
  logic [31:0] addr_i = '0;
  logic        cacheable_i = 1'b0;
  logic        ready_o;
  logic [31:0] rdata_o;
  logic        policy_rr_i = 1'b0;
  logic [5:0]  lock_base_i = '0;
  logic        inval_i = 1'b0;
  logic        mem_req_o, mem_burst_o;
  logic [31:0] mem_addr_o;
  logic        mem_valid_i = 1'b0;
  logic [31:0] mem_rdata_i = '0;

  always #2.5 clk = ~clk;

  seg_cache_ctrl uut (
    .clk_i(clk), .rst_ni(rst_ni), .req_i(req_i), .addr_i(addr_i),
    .cacheable_i(cacheable_i), .ready_o(ready_o), .rdata_o(rdata_o),
    .policy_rr_i(policy_rr_i), .lock_base_i(lock_base_i), .inval_i(inval_i),
    .mem_req_o(mem_req_o), .mem_burst_o(mem_burst_o), .mem_addr_o(mem_addr_o),
    .mem_valid_i(mem_valid_i), .mem_rdata_i(mem_rdata_i)
  );

  int total = 0;
  int bad = 0;
  bit done = 0;

  // reference model state
  int          m_state;
  bit          m_valid [8][64];
  logic [23:0] m_tag   [8][64];
  int          m_ptr   [8];
  logic [5:0]  m_lfsr;
  logic [23:0] l_tag;
  int          l_seg, l_word, l_way, l_base, m_beat, mem_cnt;
  bit          l_rr;
  logic [31:0] l_single;
  bit          inval_on_last = 0;
  bit          dut_rdy;
  string       cur_r = "R2";

  function automatic logic [31:0] memf(logic [31:0] a);
    return (a * 32'h9E37_79B1) ^ 32'h1357_2468;
  endfunction

  function automatic bit m_hit(logic [31:0] a);
    for (int w = 0; w < 64; w++)
      if (m_valid[a[7:5]][w] && m_tag[a[7:5]][w] == a[31:8]) return 1;
    return 0;
  endfunction

  task automatic chk(string r, bit ok, logic [31:0] act, logic [31:0] exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s act=%h exp=%h t=%0t", r, act, exp, $time);
    end
  endtask

  task automatic model_reset();
    m_state = 0; m_lfsr = 6'd1; m_beat = 0; mem_cnt = 0;
    for (int s = 0; s < 8; s++) begin
      m_ptr[s] = 0;
      for (int w = 0; w < 64; w++) m_valid[s][w] = 0;
    end
  endtask

  // one clock: drive bus side, compare at mid-cycle, advance model
  task automatic tick();
    logic [31:0] baddr, e_addr, e_rdata;
    bit e_req, e_burst, e_ready, mv, hit_now;
    int old_state, base, vic;
    mv = (m_state != 0) && (mem_cnt >= 2) && (mem_cnt != 5);
    baddr = (m_state == 1) ? {l_tag, 3'(l_seg), 3'(m_beat), 2'b00} : l_single;
    mem_valid_i = mv;
    mem_rdata_i = mv ? memf(baddr) : 32'hDEAD_BEEF;
    if (inval_on_last && m_state == 1 && mv && m_beat == 7) begin
      inval_i = 1'b1;
      inval_on_last = 0;
    end
    #1;
    e_req = (m_state != 0);
    e_burst = (m_state == 1);
    e_addr = (m_state == 1) ? {l_tag, 3'(l_seg), 5'b0} : l_single;
    hit_now = m_hit(addr_i);
    e_ready = 0; e_rdata = '0;
    case (m_state)
      0: begin e_ready = req_i && cacheable_i && hit_now; e_rdata = memf({addr_i[31:2], 2'b00}); end
      1: begin e_ready = mv && (m_beat == l_word); e_rdata = mem_rdata_i; end
      default: begin e_ready = mv; e_rdata = mem_rdata_i; end
    endcase
    dut_rdy = ready_o;
    begin
      string rr;
      rr = (m_state == 0) ? cur_r : (m_state == 1) ? "R4" : "R6";
      chk(rr, ready_o === e_ready, 32'(ready_o), 32'(e_ready));
      if (e_ready) chk((m_state == 0) ? "R1" : rr, rdata_o === e_rdata, rdata_o, e_rdata);
      chk((m_state == 2) ? "R6" : "R3", mem_req_o === e_req, 32'(mem_req_o), 32'(e_req));
      if (e_req) begin
        chk((m_state == 2) ? "R6" : "R3", mem_burst_o === e_burst, 32'(mem_burst_o), 32'(e_burst));
        chk((m_state == 2) ? "R6" : "R3", mem_addr_o === e_addr, mem_addr_o, e_addr);
      end
    end
    // advance model as the next rising edge would
    old_state = m_state;
    case (m_state)
      0: if (req_i) begin
        if (!cacheable_i) begin
          l_single = {addr_i[31:2], 2'b00};
          m_state = 2;
        end else if (!hit_now) begin
          base = int'(lock_base_i);
          if (policy_rr_i) vic = (m_ptr[addr_i[7:5]] < base) ? base : m_ptr[addr_i[7:5]];
          else             vic = (int'(m_lfsr) < base) ? base : int'(m_lfsr);
          l_tag = addr_i[31:8]; l_seg = int'(addr_i[7:5]); l_word = int'(addr_i[4:2]);
          l_way = vic; l_base = base; l_rr = policy_rr_i;
          m_beat = 0; m_state = 1;
        end
      end
      1: if (mv) begin
        if (m_beat == 7) begin
          m_valid[l_seg][l_way] = 1;
          m_tag[l_seg][l_way] = l_tag;
          if (l_rr) m_ptr[l_seg] = (l_way == 63) ? l_base : l_way + 1;
          m_state = 0;
        end
        m_beat++;
      end
      default: if (mv) m_state = 0;
    endcase
    if (inval_i)
      for (int s = 0; s < 8; s++)
        for (int w = 0; w < 64; w++) m_valid[s][w] = 0;
    m_lfsr = {m_lfsr[4:0], m_lfsr[5] ^ m_lfsr[4]};
    mem_cnt = (old_state == 0) ? 0 : mem_cnt + 1;
    @(negedge clk);
    if (inval_i && !req_i) inval_i = 1'b0;
  endtask

  task automatic rd(input logic [31:0] a, input bit c, output int cyc);
    req_i = 1'b1; addr_i = a; cacheable_i = c; cyc = 0;
    do begin tick(); cyc++; end while (!dut_rdy && cyc < 100);
    req_i = 1'b0;
  endtask

  task automatic settle();
    int n = 0;
    while (m_state != 0 && n < 100) begin tick(); n++; end
    tick();
  endtask

  task automatic rd_full(input logic [31:0] a, input bit c, output int cyc);
    rd(a, c, cyc);
    settle();
  endtask

  function automatic logic [31:0] mk(int tag, int seg, int word);
    return {24'(tag), 3'(seg), 3'(word), 2'b00};
  endfunction

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      bad++;
      total++;
      $display("FAIL watchdog act=timeout exp=finish");
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin
    int cyc;
    bit pred;
    model_reset();
    repeat (3) @(negedge clk);
    // R13
    chk("R13", ready_o === 1'b0, 32'(ready_o), 0);
    chk("R13", mem_req_o === 1'b0, 32'(mem_req_o), 0);
    rst_ni = 1'b1;
    tick();

    // R2 / R4: miss forwards word 0, then all words hit
    cur_r = "R2";
    rd_full(mk(16, 2, 0), 1, cyc);
    chk("R3", cyc > 1, cyc, 2);
    for (int w = 0; w < 8; w++) begin
      rd_full(mk(16, 2, w), 1, cyc);
      chk("R2", cyc == 1, cyc, 1);
    end
    rd_full(mk(512, 3, 5), 1, cyc);   // R4: critical word at beat 5
    rd_full(mk(512, 3, 7), 1, cyc);
    chk("R2", cyc == 1, cyc, 1);

    // R5: request during an ongoing fill waits for the fill to end
    cur_r = "R5";
    rd(mk(77, 4, 1), 1, cyc);
    rd_full(mk(16, 2, 3), 1, cyc);
    chk("R5", cyc > 1, cyc, 2);
    rd_full(mk(77, 4, 6), 1, cyc);
    chk("R5", cyc == 1, cyc, 1);

    // R6: uncached read allocates nothing
    cur_r = "R6";
    rd_full(mk(900, 6, 2), 0, cyc);
    rd_full(mk(900, 6, 2), 1, cyc);
    chk("R6", cyc > 1, cyc, 2);

    // R7: random victims in segment 5
    cur_r = "R7";
    for (int i = 0; i < 70; i++) rd_full(mk(1000 + i, 5, i % 8), 1, cyc);
    for (int i = 0; i < 70; i++) begin
      pred = m_hit(mk(1000 + i, 5, 0));
      rd_full(mk(1000 + i, 5, 0), 1, cyc);
      chk("R7", (cyc == 1) == pred, cyc, pred ? 1 : 2);
    end

    // R10: invalidate
    cur_r = "R10";
    inval_i = 1'b1; tick(); inval_i = 1'b0;
    rd_full(mk(16, 2, 0), 1, cyc);
    chk("R10", cyc > 1, cyc, 2);

    // R8: round robin fills segment 1 in way order
    cur_r = "R8";
    policy_rr_i = 1'b1;
    for (int i = 0; i < 64; i++) rd_full(mk(2000 + i, 1, 0), 1, cyc);
    for (int i = 0; i < 64; i++) begin
      rd_full(mk(2000 + i, 1, 4), 1, cyc);
      chk("R8", cyc == 1, cyc, 1);
    end

    // R9: lock ways 0..7, then evict under both policies
    cur_r = "R9";
    lock_base_i = 6'd8;
    for (int i = 0; i < 20; i++) rd_full(mk(3000 + i, 1, 1), 1, cyc);
    rd_full(mk(2008, 1, 0), 1, cyc);
    chk("R8", cyc > 1, cyc, 2);
    policy_rr_i = 1'b0;
    lock_base_i = 6'd40;
    for (int i = 0; i < 30; i++) rd_full(mk(4000 + i, 1, 2), 1, cyc);
    for (int i = 0; i < 8; i++) begin
      rd_full(mk(2000 + i, 1, 7), 1, cyc);
      chk("R9", cyc == 1, cyc, 1);
    end
    lock_base_i = 6'd0;

    // R11: invalidate on the final fill beat
    cur_r = "R11";
    inval_on_last = 1;
    rd_full(mk(5000, 7, 3), 1, cyc);
    rd_full(mk(5000, 7, 3), 1, cyc);
    chk("R11", cyc > 1, cyc, 2);

    // R12: hit and invalidate in the same cycle
    cur_r = "R12";
    rd_full(mk(5000, 7, 4), 1, cyc);
    req_i = 1'b1; addr_i = mk(5000, 7, 4); cacheable_i = 1'b1; inval_i = 1'b1;
    tick();
    chk("R12", dut_rdy == 1'b1, 32'(dut_rdy), 1);
    req_i = 1'b0; inval_i = 1'b0;
    tick();
    rd_full(mk(5000, 7, 4), 1, cyc);
    chk("R12", cyc > 1, cyc, 2);

    done = 1;
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule